// File: doc/BRIEF.md
# Trap Entry Sequencer

This block turns a single trap request into the complete architectural state update for trap entry, finished in one clock edge. The request is either a synchronous exception or an asynchronous interrupt, and it carries three things: a cause code, the PC of the trapping instruction, and the faulting address. The block keeps the trap state itself:

- the current privilege level;
- the interrupt-enable and previous-privilege fields of the status word;
- the cause, exception PC and trap-value registers for both the supervisor level and the machine level;
- both trap vector bases and both delegation masks.

On a request the block works out three results:

- **Target level.** Delegation bits are indexed by the effective cause. A request from supervisor or user level can be sent down to supervisor level; everything else is handled at machine level.
- **Saved state.** Only the target level's enable, previous-enable and previous-privilege fields are saved and then cleared or updated.
- **Handler address.** It comes from the target level's vector base. In vectored mode, interrupts are spread out at four bytes per cause.

The new PC appears on the cycle after the request, together with a one-cycle valid strobe. A small preload port fills the masks, vector bases, status fields and privilege before a test runs.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, privilege is machine (code 3), and every status field, mask, vector base, cause, EPC and trap-value register reads zero. The new PC reads zero and the valid strobe is low.
- R2: Privilege codes are user 0, supervisor 1, machine 3. The delegation mask is the interrupt mask for interrupts and the exception mask for exceptions. When the current privilege is not machine and the mask bit at the effective cause is set, the trap goes to supervisor. Otherwise it goes to machine.
- R3: On supervisor entry, status bit 5 takes the old bit 1, bit 8 takes bit 0 of the old privilege, and bit 1 clears. Bits 3, 7 and 12:11 keep their values.
- R4: On machine entry, status bit 7 takes the old bit 3, bits 12:11 take the old privilege, and bit 3 clears. Bits 1, 5 and 8 keep their values.
- R5: The target level's cause register receives the effective cause in its low bits and the interrupt flag in bit 63, with zeros everywhere else. The other level's cause, EPC and trap value stay unchanged.
- R6: The target level's EPC receives the trap PC input.
- R7: The target level's trap value receives the fault address only for an exception with effective cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception, and for every interrupt, it receives zero.
- R8: The new PC is the target vector base with bits 1:0 cleared. When the base's bits 1:0 equal 1 and the trap is an interrupt, four times the cause is added; modes 0, 2 and 3 are direct. The PC and a valid pulse appear the cycle after the request, and the pulse lasts one cycle.
- R9: An exception with cause 8 is re-coded by the current privilege: it becomes 11 from machine, 9 from supervisor, and stays 8 from user. Delegation uses the re-coded cause.
- R10: After entry, the privilege equals the target level.
- R11: The preload selector picks what is written: 0 exception mask, 1 interrupt mask, 2 machine vector, 3 supervisor vector, 4 status, 5 privilege. A status preload copies only bits 1, 3, 5, 7, 8 and 12:11. A privilege preload of 2 is stored as 0. When a trap and a preload arrive in the same cycle, the preload is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | One-cycle trap request |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | 6 | Raw cause code |
| trap_pc_i | input | 64 | PC of the trapping instruction |
| trap_addr_i | input | 64 | Faulting address |
| pl_we_i | input | 1 | Preload write enable |
| pl_sel_i | input | 3 | Preload target selector |
| pl_data_i | input | 64 | Preload data |
| priv_o | output | 2 | Current privilege |
| status_o | output | 64 | Status word (fields only) |
| mcause_o | output | 64 | Machine cause |
| mepc_o | output | 64 | Machine EPC |
| mtval_o | output | 64 | Machine trap value |
| scause_o | output | 64 | Supervisor cause |
| sepc_o | output | 64 | Supervisor EPC |
| stval_o | output | 64 | Supervisor trap value |
| new_pc_o | output | 64 | Handler PC |
| pc_valid_o | output | 1 | Handler PC valid strobe |

## Verification
The bench targets the cases where a routing slip is easy to miss:

- **Environment call from machine level with the matching delegation bit set.** A design that checked delegation before re-coding, or ignored the privilege guard, would drop into supervisor level.
- **Vectored mode with exceptions and with modes 2 and 3.** A design that offsets every trap, or decodes only one mode bit, would jump to the wrong handler.
- **Interrupts whose cause matches a fault code.** A design that loads the trap value for those would leak an address.
- **A preload colliding with a trap.** A design that lets the preload win would corrupt the vector base that a later trap reads back through the new PC.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    PL_EDELEG = 3'd0,
    PL_IDELEG = 3'd1,
    PL_MVEC   = 3'd2,
    PL_SVEC   = 3'd3,
    PL_STAT   = 3'd4,
    PL_PRIV   = 3'd5
  } pl_sel_e;

  typedef struct packed {
    logic       sie;
    logic       mie;
    logic       spie;
    logic       mpie;
    logic       spp;
    logic [1:0] mpp;
  } trap_stat_t;

  localparam int unsigned ST_SIE  = 1;
  localparam int unsigned ST_MIE  = 3;
  localparam int unsigned ST_SPIE = 5;
  localparam int unsigned ST_MPIE = 7;
  localparam int unsigned ST_SPP  = 8;
  localparam int unsigned ST_MPP  = 11;

  localparam int unsigned ECALL_U = 8;
  localparam int unsigned ECALL_S = 9;
  localparam int unsigned ECALL_M = 11;

  function automatic logic addr_fault(input int unsigned c);
    case (c)
      0, 1, 4, 5, 6, 7, 12, 13, 15: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned CAUSE_W = $clog2(XLEN)
) (
  input  priv_e              priv_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    edeleg_i,
  input  logic [XLEN-1:0]    ideleg_i,
  input  logic [XLEN-1:0]    addr_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               to_s_o,
  output logic [XLEN-1:0]    tval_o
);
  logic [XLEN-1:0] deleg;

  // environment call re-coded by originating level
  always_comb begin
    cause_o = cause_i;
    if (!irq_i && int'(cause_i) == ECALL_U) begin
      unique case (priv_i)
        PRIV_M:  cause_o = CAUSE_W'(ECALL_M);
        PRIV_S:  cause_o = CAUSE_W'(ECALL_S);
        default: cause_o = CAUSE_W'(ECALL_U);
      endcase
    end
  end

  assign deleg  = irq_i ? ideleg_i : edeleg_i;
  assign to_s_o = (priv_i != PRIV_M) && deleg[cause_o];
  assign tval_o = (!irq_i && addr_fault(int'(cause_o))) ? addr_i : '0;
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int unsigned XLEN   = 64,
  parameter bit          VEC_EN = 1'b1,
  localparam int unsigned CAUSE_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);
  logic [XLEN-1:0] base;
  assign base = {tvec_i[XLEN-1:2], 2'b00};

  generate
    if (VEC_EN) begin : g_vec
      logic [XLEN-1:0] ofs;
      assign ofs  = {{(XLEN-CAUSE_W-2){1'b0}}, cause_i, 2'b00};
      assign pc_o = (irq_i && tvec_i[1:0] == 2'b01) ? base + ofs : base;
    end else begin : g_direct
      logic unused_v;
      assign unused_v = irq_i ^ (^cause_i) ^ (^tvec_i[1:0]);
      assign pc_o = base;
    end
  endgenerate
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic               trap_irq_i,
  input  logic               to_s_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    tval_i,
  input  logic [XLEN-1:0]    vec_pc_i,
  input  logic               pl_we_i,
  input  logic [2:0]         pl_sel_i,
  input  logic [XLEN-1:0]    pl_data_i,
  output logic [XLEN-1:0]    edeleg_o,
  output logic [XLEN-1:0]    ideleg_o,
  output logic [XLEN-1:0]    mtvec_o,
  output logic [XLEN-1:0]    stvec_o,
  output priv_e              priv_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    stval_o,
  output logic [XLEN-1:0]    new_pc_o,
  output logic               pc_valid_o
);
  trap_stat_t      stat_q;
  priv_e           priv_q;
  logic [XLEN-1:0] cause_word;

  assign cause_word = {trap_irq_i, {(XLEN-1-CAUSE_W){1'b0}}, cause_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q     <= '0;
      priv_q     <= PRIV_M;
      edeleg_o   <= '0;
      ideleg_o   <= '0;
      mtvec_o    <= '0;
      stvec_o    <= '0;
      mcause_o   <= '0;
      mepc_o     <= '0;
      mtval_o    <= '0;
      scause_o   <= '0;
      sepc_o     <= '0;
      stval_o    <= '0;
      new_pc_o   <= '0;
      pc_valid_o <= 1'b0;
    end else begin
      pc_valid_o <= trap_valid_i;
      if (trap_valid_i) begin
        new_pc_o <= vec_pc_i;
        if (to_s_i) begin
          stat_q.spie <= stat_q.sie;
          stat_q.spp  <= priv_q[0];
          stat_q.sie  <= 1'b0;
          scause_o    <= cause_word;
          sepc_o      <= pc_i;
          stval_o     <= tval_i;
          priv_q      <= PRIV_S;
        end else begin
          stat_q.mpie <= stat_q.mie;
          stat_q.mpp  <= priv_q;
          stat_q.mie  <= 1'b0;
          mcause_o    <= cause_word;
          mepc_o      <= pc_i;
          mtval_o     <= tval_i;
          priv_q      <= PRIV_M;
        end
      end else if (pl_we_i) begin
        case (pl_sel_e'(pl_sel_i))
          PL_EDELEG: edeleg_o <= pl_data_i;
          PL_IDELEG: ideleg_o <= pl_data_i;
          PL_MVEC:   mtvec_o  <= pl_data_i;
          PL_SVEC:   stvec_o  <= pl_data_i;
          PL_STAT: begin
            stat_q.sie  <= pl_data_i[ST_SIE];
            stat_q.mie  <= pl_data_i[ST_MIE];
            stat_q.spie <= pl_data_i[ST_SPIE];
            stat_q.mpie <= pl_data_i[ST_MPIE];
            stat_q.spp  <= pl_data_i[ST_SPP];
            stat_q.mpp  <= pl_data_i[ST_MPP+:2];
          end
          PL_PRIV:   priv_q <= (pl_data_i[1:0] == PRIV_R) ? PRIV_U : priv_e'(pl_data_i[1:0]);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[ST_SIE]      = stat_q.sie;
    status_o[ST_MIE]      = stat_q.mie;
    status_o[ST_SPIE]     = stat_q.spie;
    status_o[ST_MPIE]     = stat_q.mpie;
    status_o[ST_SPP]      = stat_q.spp;
    status_o[ST_MPP+:2]   = stat_q.mpp;
  end
  assign priv_o = priv_q;

  AST_S_IE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && to_s_i) |=> (!stat_q.sie && stat_q.spie == $past(stat_q.sie))); // R3
  AST_M_IE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !to_s_i) |=> (!stat_q.mie && stat_q.mpp == $past(priv_q))); // R4
  AST_PC_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> pc_valid_o); // R8
  AST_PC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_valid_o |-> (new_pc_o[1:0] == 2'b00)); // R8
  AST_IRQ_NO_TVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && trap_irq_i && !to_s_i) |=> (mtval_o == '0)); // R7
  AST_EPC_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !to_s_i) |=> (mepc_o == $past(pc_i))); // R6
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter bit          VEC_EN = 1'b1,
  localparam int unsigned CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic               trap_irq_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic [XLEN-1:0]    trap_addr_i,
  input  logic               pl_we_i,
  input  logic [2:0]         pl_sel_i,
  input  logic [XLEN-1:0]    pl_data_i,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    stval_o,
  output logic [XLEN-1:0]    new_pc_o,
  output logic               pc_valid_o
);
  priv_e              priv;
  logic [XLEN-1:0]    edeleg, ideleg, mtvec, stvec, tval, vec_pc, tvec_sel;
  logic [CAUSE_W-1:0] cause_eff;
  logic               to_s;

  trap_route #(.XLEN(XLEN)) u_route (
    .priv_i   (priv),
    .irq_i    (trap_irq_i),
    .cause_i  (trap_cause_i),
    .edeleg_i (edeleg),
    .ideleg_i (ideleg),
    .addr_i   (trap_addr_i),
    .cause_o  (cause_eff),
    .to_s_o   (to_s),
    .tval_o   (tval)
  );

  assign tvec_sel = to_s ? stvec : mtvec;

  trap_vector #(.XLEN(XLEN), .VEC_EN(VEC_EN)) u_vec (
    .tvec_i  (tvec_sel),
    .irq_i   (trap_irq_i),
    .cause_i (cause_eff),
    .pc_o    (vec_pc)
  );

  trap_state #(.XLEN(XLEN)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_valid_i (trap_valid_i),
    .trap_irq_i   (trap_irq_i),
    .to_s_i       (to_s),
    .cause_i      (cause_eff),
    .pc_i         (trap_pc_i),
    .tval_i       (tval),
    .vec_pc_i     (vec_pc),
    .pl_we_i      (pl_we_i),
    .pl_sel_i     (pl_sel_i),
    .pl_data_i    (pl_data_i),
    .edeleg_o     (edeleg),
    .ideleg_o     (ideleg),
    .mtvec_o      (mtvec),
    .stvec_o      (stvec),
    .priv_o       (priv),
    .status_o     (status_o),
    .mcause_o     (mcause_o),
    .mepc_o       (mepc_o),
    .mtval_o      (mtval_o),
    .scause_o     (scause_o),
    .sepc_o       (sepc_o),
    .stval_o      (stval_o),
    .new_pc_o     (new_pc_o),
    .pc_valid_o   (pc_valid_o)
  );

  assign priv_o = priv;

  AST_M_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !to_s) |=> (priv_o == PRIV_M)); // R10
  AST_NO_S_FROM_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_o == PRIV_M) |-> !to_s); // R2
  AST_M_ECALL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !trap_irq_i && int'(trap_cause_i) == ECALL_U && priv_o == PRIV_M)
    |=> (mcause_o == XLEN'(ECALL_M))); // R9
  AST_CAUSE_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !to_s) |=> (mcause_o[XLEN-1] == $past(trap_irq_i))); // R5
endmodule

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
  localparam int XLEN = 64;
  localparam int CW   = 6;
  localparam logic [63:0] ST_MASK = 64'h1000 | 64'h800 | 64'h100 | 64'h80 | 64'h20 | 64'h8 | 64'h2;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic            rst_ni, trap_valid_i, trap_irq_i, pl_we_i;
  logic [CW-1:0]   trap_cause_i;
  logic [63:0]     trap_pc_i, trap_addr_i, pl_data_i;
  logic [2:0]      pl_sel_i;
  logic [1:0]      priv_o;
  logic [63:0]     status_o, mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o, new_pc_o;
  logic            pc_valid_o;

  trap_entry_seq u0 (.*);

  int n_run = 0, n_fail = 0;
  logic [63:0] m_ed, m_id, m_mtv, m_stv, m_st, m_mc, m_me, m_mt, m_sc, m_se, m_stl, m_pc;
  logic [1:0]  m_pr;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic fault_c(input int c);
    return (c inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
  endfunction

  task automatic model_trap(input logic irq, input int c_in, input logic [63:0] pc, input logic [63:0] addr);
    int c; logic [63:0] dm, tv, vb; logic to_s;
    c = c_in;
    if (!irq && c == 8) c = (m_pr == 2'd3) ? 11 : (m_pr == 2'd1) ? 9 : 8;  // R9
    dm   = irq ? m_id : m_ed;
    to_s = (m_pr != 2'd3) && dm[c];
    tv   = (!irq && fault_c(c)) ? addr : 64'd0;
    vb   = to_s ? m_stv : m_mtv;
    m_pc = {vb[63:2], 2'b00};
    if (irq && vb[1:0] == 2'b01) m_pc = m_pc + 64'(c) * 4;
    if (to_s) begin
      m_st[5] = m_st[1]; m_st[8] = m_pr[0]; m_st[1] = 1'b0;
      m_sc = {irq, 63'(c)}; m_se = pc; m_stl = tv; m_pr = 2'd1;
    end else begin
      m_st[7] = m_st[3]; m_st[12:11] = m_pr; m_st[3] = 1'b0;
      m_mc = {irq, 63'(c)}; m_me = pc; m_mt = tv; m_pr = 2'd3;
    end
  endtask

  task automatic model_pl(input logic [2:0] s, input logic [63:0] d);
    case (s)
      3'd0: m_ed = d;
      3'd1: m_id = d;
      3'd2: m_mtv = d;
      3'd3: m_stv = d;
      3'd4: m_st = d & ST_MASK;
      3'd5: m_pr = (d[1:0] == 2'd2) ? 2'd0 : d[1:0];
      default: ;
    endcase
  endtask

  task automatic preload(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk_i);
    pl_we_i = 1'b1; pl_sel_i = s; pl_data_i = d;
    @(negedge clk_i);
    pl_we_i = 1'b0;
    model_pl(s, d);
  endtask

  task automatic compare_all(input logic irq);
    chk("R10", "priv", {62'd0, priv_o}, {62'd0, m_pr});
    chk((m_pr == 2'd1) ? "R3" : "R4", "status", status_o, m_st);
    chk("R5", "mcause", mcause_o, m_mc);
    chk("R5", "scause", scause_o, m_sc);
    chk("R6", "mepc", mepc_o, m_me);
    chk("R6", "sepc", sepc_o, m_se);
    chk("R7", irq ? "mtval irq" : "mtval", mtval_o, m_mt);
    chk("R7", "stval", stval_o, m_stl);
    chk("R8", "new_pc", new_pc_o, m_pc);
    chk("R8", "pc_valid", 64'(pc_valid_o), 64'd1);
  endtask

  // drop_pl: raise a preload in the same cycle; it must be dropped (R11)
  task automatic trap(input logic irq, input int c, input logic [63:0] pc, input logic [63:0] addr,
                      input logic clash, input logic [2:0] s, input logic [63:0] d);
    @(negedge clk_i);
    trap_valid_i = 1'b1; trap_irq_i = irq; trap_cause_i = CW'(c);
    trap_pc_i = pc; trap_addr_i = addr;
    pl_we_i = clash; pl_sel_i = s; pl_data_i = d;
    model_trap(irq, c, pc, addr);
    @(negedge clk_i);
    trap_valid_i = 1'b0; pl_we_i = 1'b0;
    compare_all(irq);
    @(negedge clk_i);
    chk("R8", "pc_valid drop", 64'(pc_valid_o), 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    rst_ni = 1'b0; trap_valid_i = 0; trap_irq_i = 0; trap_cause_i = '0;
    trap_pc_i = '0; trap_addr_i = '0; pl_we_i = 0; pl_sel_i = '0; pl_data_i = '0;
    {m_ed, m_id, m_mtv, m_stv, m_st, m_mc, m_me, m_mt, m_sc, m_se, m_stl, m_pc} = '0;
    m_pr = 2'd3;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "priv", {62'd0, priv_o}, 64'd3);
    chk("R1", "status", status_o, 64'd0);
    chk("R1", "mcause", mcause_o, 64'd0);
    chk("R1", "scause", scause_o, 64'd0);
    chk("R1", "new_pc", new_pc_o, 64'd0);
    chk("R1", "pc_valid", 64'(pc_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 privilege code 2 stored as user
    preload(3'd5, 64'd2);
    chk("R11", "priv 2->0", {62'd0, priv_o}, 64'd0);
    // R11 status preload only takes field bits
    preload(3'd4, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11", "status mask", status_o, ST_MASK);

    // R9 ecall from user, delegated
    preload(3'd0, 64'h0000_0000_0000_0B00);
    preload(3'd3, 64'h0000_0000_8000_0001);
    preload(3'd2, 64'h0000_0000_4000_0001);
    trap(1'b0, 8, 64'h100, 64'hDEAD, 1'b0, 3'd0, 64'd0);
    chk("R9", "u ecall scause", scause_o, 64'd8);
    // R9 ecall from supervisor -> 9 (delegated since bit 9 set)
    trap(1'b0, 8, 64'h104, 64'hDEAD, 1'b0, 3'd0, 64'd0);
    chk("R9", "s ecall scause", scause_o, 64'd9);
    // R2 R9 ecall from machine with bit 11 set stays machine
    preload(3'd5, 64'd3);
    trap(1'b0, 8, 64'h108, 64'hDEAD, 1'b0, 3'd0, 64'd0);
    chk("R9", "m ecall mcause", mcause_o, 64'd11);
    chk("R2", "m stays m", {62'd0, priv_o}, 64'd3);

    // R8 vectored interrupt in machine mode: 0x4000_0000 + 7*4
    trap(1'b1, 7, 64'h200, 64'h55, 1'b0, 3'd0, 64'd0);
    chk("R8", "vectored irq", new_pc_o, 64'h4000_001C);
    // R8 exception with mode 1 is direct
    trap(1'b0, 2, 64'h204, 64'h55, 1'b0, 3'd0, 64'd0);
    chk("R8", "vectored exc", new_pc_o, 64'h4000_0000);
    // R8 mode 3 is direct for interrupts
    preload(3'd2, 64'h0000_0000_4000_0003);
    trap(1'b1, 5, 64'h208, 64'h55, 1'b0, 3'd0, 64'd0);
    chk("R8", "mode3 irq", new_pc_o, 64'h4000_0000);
    // R11 preload colliding with trap is dropped; later trap shows old vector
    trap(1'b1, 3, 64'h20C, 64'h55, 1'b1, 3'd2, 64'h0000_0000_7700_0000);
    trap(1'b0, 4, 64'h210, 64'h66, 1'b0, 3'd0, 64'd0);
    chk("R11", "clash dropped", new_pc_o, 64'h4000_0000);
    // R7 fault address captured for load misaligned
    chk("R7", "fault tval", mtval_o, 64'h66);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int np;
      np = $urandom_range(0, 3);
      for (int k = 0; k < np; k++) begin
        logic [2:0] s;
        logic [63:0] d;
        s = 3'($urandom_range(0, 5));
        d = {$urandom, $urandom};
        preload(s, d);
      end
      trap(1'($urandom_range(0, 1)), $urandom_range(0, 15), {$urandom, $urandom},
           {$urandom, $urandom}, 1'b0, 3'd0, 64'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule